// File: doc/BRIEF.md
# Two-Bit Sample Deserializer with Word-Phase Disciplining

This block takes a serial stream of two-bit samples (a sign bit and a magnitude bit) at the fast sample clock. It spreads the stream onto parallel lanes at one sixteenth of that rate. The sign bit and the magnitude bit each pass through their own 1:16 deserializer, and each deserializer has its own divide-by-16 word counter. The power-up state of each counter is arbitrary, and is modelled here by a start-phase input that is loaded while reset is held. Left alone, the two halves of every sample could therefore land on different word boundaries.

A per-deserializer phase comparator checks whether the counter's terminal-count strobe sits in the fast-clock slot marked by an external reference word tick. On a mismatch it stalls that counter for one fast cycle, which rotates its word boundary by one bit. It then waits a settle period before it compares again. The controller behaves like a phase-locked loop with sixteen discrete phase states.

Once both counters have matched for a run of consecutive ticks, the lock flag rises and slipping stops. After lock the controller keeps checking. A short burst of mismatches is tolerated, while a longer one drops the lock and restarts the search. Parallel words are presented with a one-cycle valid strobe while the block is locked.

Top module: `deser_phase_lock`

## Requirements
- R1: On each `word_vld` pulse, `sgn_word` bit i holds the sign bit of the i-th sample of the 16 most recent samples, oldest first. Bit 0 is the sample taken 15 cycles before the last one, and bit 15 is the last sample consumed before the pulse.
- R2: Every `word_vld` pulse comes one cycle after a cycle in which `ref_tick` was high. The captured word therefore ends on the reference word boundary.
- R3: On each `word_vld` pulse, `mag_word` holds the magnitude bits of exactly the same 16 samples as `sgn_word`, in the same lane order.
- R4: From any pair of start phases, `locked` rises within a bounded time, and each divider takes at most 15 slips before that. Equal start phases give equal slip counts.
- R5: A slip output is high for a single cycle at a time, and neither slip output is ever high while `locked` is high.
- R6: After a slip, the same divider slips again only after at least SETTLE+1 (17) further reference ticks.
- R7: `locked` rises exactly SETTLE+LOCK_N (80) reference ticks after the most recent slip of either divider. This is the settle period plus 64 consecutive matching comparisons.
- R8: While locked, three consecutive mismatched reference ticks leave `locked` high with no slip. The fourth consecutive mismatch clears `locked` in the cycle after that tick.
- R9: After lock is lost, the search resumes. If the reference moved one cycle later, each divider relocks after exactly 1 slip. If it moved one cycle earlier, each divider needs exactly 15 slips.
- R10: `word_vld` is high only while `locked` is high, and it pulses exactly once per 16 cycles when the reference is steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sgn_start | input | 4 | Power-up state of the sign divider, loaded during reset |
| mag_start | input | 4 | Power-up state of the magnitude divider, loaded during reset |
| sgn_bit | input | 1 | Serial sign bit, one per cycle |
| mag_bit | input | 1 | Serial magnitude bit, one per cycle |
| ref_tick | input | 1 | One-cycle pulse marking the reference word boundary, every 16 cycles |
| sgn_slip | output | 1 | Stall pulse applied to the sign divider |
| mag_slip | output | 1 | Stall pulse applied to the magnitude divider |
| sgn_word | output | 16 | Parallel sign lanes, lane 0 earliest |
| mag_word | output | 16 | Parallel magnitude lanes, lane 0 earliest |
| word_vld | output | 1 | One-cycle strobe qualifying the parallel words |
| locked | output | 1 | Both dividers aligned to the reference |

## Verification
The bench starts the two dividers at equal and at unequal phases, including the phase that needs the full fifteen slips. A controller that stepped the wrong direction, or skipped the settle wait, would show extra slips, or slips closer than seventeen ticks apart. It moves the reference by one cycle for exactly three ticks and then back; an off-by-one loss counter would drop lock there, or fail to drop it on a fourth mismatch. A permanent shift in both directions checks the 1- and 15-slip relock counts. Every delivered word is compared lane by lane against the serial history, which exposes reversed lane order or a sign/magnitude boundary offset.

// File: rtl/sd_pkg.sv
package sd_pkg;
  // Outcome of one reference tick as seen by a phase comparator
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_WAIT  = 2'd1,
    EV_MATCH = 2'd2,
    EV_MISS  = 2'd3
  } cmp_ev_e;

  localparam int unsigned NDIV = 2;  // sign and magnitude deserializers
endpackage

// File: rtl/sd_deser.sv
module sd_deser #(
  parameter int LANES = 16,
  localparam int CW = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    start_phase,
  input  logic             bit_in,
  input  logic             slip,
  output logic             tc,
  output logic [LANES-1:0] word
);
  logic [CW-1:0]    cnt_q, cnt_nxt;
  logic [LANES-1:0] sh_q, sh_nxt;
  logic [LANES-1:0] word_q, word_nxt;

  // terminal count marks the last bit of a word
  assign tc = (cnt_q == CW'(LANES - 1));

  always_comb begin
    cnt_nxt  = slip ? cnt_q : cnt_q + CW'(1);
    sh_nxt   = {bit_in, sh_q[LANES-1:1]};
    word_nxt = tc ? sh_nxt : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= start_phase;
      sh_q   <= '0;
      word_q <= '0;
    end else begin
      cnt_q  <= cnt_nxt;
      sh_q   <= sh_nxt;
      word_q <= word_nxt;
    end
  end

  assign word = word_q;
endmodule

// File: rtl/sd_phase_ctl.sv
module sd_phase_ctl
  import sd_pkg::*;
#(
  parameter int SETTLE = 16,
  parameter int LOCK_N = 64,
  parameter int LOSS_N = 4,
  localparam int SW = $clog2(SETTLE + 1),
  localparam int RW = $clog2(LOCK_N + 1),
  localparam int MW = $clog2(LOSS_N + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic tc,
  input  logic locked,
  input  logic drop,
  output logic slip,
  output logic run_full,
  output logic miss_hit
);
  logic [SW-1:0] settle_q, settle_nxt;
  logic [RW-1:0] run_q, run_nxt;
  logic [MW-1:0] miss_q, miss_nxt;
  logic          slip_q, slip_nxt;
  cmp_ev_e       ev;

  always_comb begin
    if (!ref_tick)            ev = EV_NONE;
    else if (settle_q != '0)  ev = EV_WAIT;
    else if (tc)              ev = EV_MATCH;
    else                      ev = EV_MISS;
  end

  assign run_full = (run_q == RW'(LOCK_N));
  assign miss_hit = locked && (ev == EV_MISS) && (miss_q == MW'(LOSS_N - 1));

  always_comb begin
    settle_nxt = settle_q;
    run_nxt    = run_q;
    miss_nxt   = miss_q;
    slip_nxt   = 1'b0;
    if (drop) begin
      run_nxt  = '0;
      miss_nxt = '0;
    end else begin
      unique case (ev)
        EV_WAIT:  settle_nxt = settle_q - SW'(1);
        EV_MATCH: begin
          miss_nxt = '0;
          if (!run_full) run_nxt = run_q + RW'(1);
        end
        EV_MISS: begin
          if (locked) begin
            miss_nxt = miss_q + MW'(1);
          end else begin
            slip_nxt   = 1'b1;
            settle_nxt = SW'(SETTLE);
            run_nxt    = '0;
            miss_nxt   = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= '0;
      run_q    <= '0;
      miss_q   <= '0;
      slip_q   <= 1'b0;
    end else begin
      settle_q <= settle_nxt;
      run_q    <= run_nxt;
      miss_q   <= miss_nxt;
      slip_q   <= slip_nxt;
    end
  end

  assign slip = slip_q;
endmodule

// File: rtl/deser_phase_lock.sv
module deser_phase_lock
  import sd_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int SETTLE = 16,
  parameter int LOCK_N = 64,
  parameter int LOSS_N = 4,
  localparam int CW = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    sgn_start,
  input  logic [CW-1:0]    mag_start,
  input  logic             sgn_bit,
  input  logic             mag_bit,
  input  logic             ref_tick,
  output logic             sgn_slip,
  output logic             mag_slip,
  output logic [LANES-1:0] sgn_word,
  output logic [LANES-1:0] mag_word,
  output logic             word_vld,
  output logic             locked
);
  logic [1:0]       rsync_q;
  logic             rst_ni;
  logic [NDIV-1:0]  bit_v, tc_v, slip_v, full_v, hit_v;
  logic [CW-1:0]    start_v [NDIV];
  logic [LANES-1:0] word_v  [NDIV];
  logic             lock_q, lock_nxt, vld_q, vld_nxt, drop;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  assign bit_v      = {mag_bit, sgn_bit};
  assign start_v[0] = sgn_start;
  assign start_v[1] = mag_start;
  assign drop       = lock_q && (|hit_v);

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    sd_deser #(.LANES(LANES)) u_deser (
      .clk(clk), .rst_n(rst_ni), .start_phase(start_v[g]),
      .bit_in(bit_v[g]), .slip(slip_v[g]), .tc(tc_v[g]), .word(word_v[g])
    );
    sd_phase_ctl #(.SETTLE(SETTLE), .LOCK_N(LOCK_N), .LOSS_N(LOSS_N)) u_ctl (
      .clk(clk), .rst_n(rst_ni), .ref_tick(ref_tick), .tc(tc_v[g]),
      .locked(lock_q), .drop(drop), .slip(slip_v[g]),
      .run_full(full_v[g]), .miss_hit(hit_v[g])
    );
  end

  always_comb begin
    lock_nxt = lock_q ? !(|hit_v) : (&full_v);
    vld_nxt  = lock_q && tc_v[0] && ref_tick;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      lock_q <= lock_nxt;
      vld_q  <= vld_nxt;
    end
  end

  assign sgn_slip = slip_v[0];
  assign mag_slip = slip_v[1];
  assign sgn_word = word_v[0];
  assign mag_word = word_v[1];
  assign word_vld = vld_q;
  assign locked   = lock_q;
endmodule

// File: rtl/sd_phase_chk.sv
module sd_phase_chk #(
  parameter int SETTLE = 16,
  localparam int GW = $clog2(SETTLE + 2)
) (
  input logic clk,
  input logic rst_n,
  input logic ref_tick,
  input logic sgn_slip,
  input logic mag_slip,
  input logic word_vld,
  input logic locked
);
  localparam logic [GW-1:0] GMAX = '1;
  logic [GW-1:0] gap_s, gap_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_s <= GMAX;
      gap_m <= GMAX;
    end else begin
      if (sgn_slip)                     gap_s <= '0;
      else if (ref_tick && gap_s != GMAX) gap_s <= gap_s + GW'(1);
      if (mag_slip)                     gap_m <= '0;
      else if (ref_tick && gap_m != GMAX) gap_m <= gap_m + GW'(1);
    end
  end

  // R5
  sgn_slip_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) sgn_slip |=> !sgn_slip);
  // R5
  mag_slip_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) mag_slip |=> !mag_slip);
  // R5
  lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) locked |-> !(sgn_slip || mag_slip));
  // R6
  sgn_settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) sgn_slip |-> gap_s >= GW'(SETTLE + 1));
  // R6
  mag_settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) mag_slip |-> gap_m >= GW'(SETTLE + 1));
  // R2
  vld_on_ref_chk: assert property (@(posedge clk) disable iff (!rst_n) word_vld |-> $past(ref_tick));
  // R10
  vld_locked_chk: assert property (@(posedge clk) disable iff (!rst_n) word_vld |-> $past(locked));
  // R7
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(locked) |-> $past(ref_tick, 2));
endmodule

bind deser_phase_lock sd_phase_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .sgn_slip(sgn_slip),
  .mag_slip(mag_slip), .word_vld(word_vld), .locked(locked)
);

// File: tb/tb_deser_phase_lock.sv
module tb_deser_phase_lock;
  localparam int CLK_P  = 10;
  localparam int SETTLE = 16;
  localparam int LOCK_N = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] sgn_start, mag_start;
  logic sgn_bit, mag_bit, ref_tick;
  logic sgn_slip, mag_slip, word_vld, locked;
  logic [15:0] sgn_word, mag_word;

  always #(CLK_P/2) clk = ~clk;

  deser_phase_lock dut (
    .clk(clk), .rst_n(rst_n), .sgn_start(sgn_start), .mag_start(mag_start),
    .sgn_bit(sgn_bit), .mag_bit(mag_bit), .ref_tick(ref_tick),
    .sgn_slip(sgn_slip), .mag_slip(mag_slip), .sgn_word(sgn_word),
    .mag_word(mag_word), .word_vld(word_vld), .locked(locked)
  );

  int errors = 0, checks = 0;
  int n = 0, nt = 0, adj = 0;
  logic sh_h [32], mh_h [32], rf_h [32];
  int slips_s, slips_m, tk_s, tk_m, since, vld_cnt;
  bit any_slip, prev_lock, track;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input bit mag, input int at);
    logic [15:0] w;
    for (int i = 0; i < 16; i++) w[i] = mag ? mh_h[(at - 16 + i) & 31] : sh_h[(at - 16 + i) & 31];
    return w;
  endfunction

  // runs at the falling edge: outputs reflect the edge that consumed index n-1
  task automatic observe();
    bit tk;
    tk = (n > 0) && rf_h[(n - 1) & 31];
    if (!track) return;
    if (word_vld) begin
      vld_cnt++;
      chk(sgn_word == exp_word(1'b0, n), "R1 sign lanes", int'(sgn_word), int'(exp_word(1'b0, n)));
      chk(mag_word == exp_word(1'b1, n), "R3 magnitude lanes", int'(mag_word), int'(exp_word(1'b1, n)));
      chk(tk, "R2 word ends on reference tick", int'(tk), 1);
    end
    if (tk) begin tk_s++; tk_m++; since++; end
    if (sgn_slip || mag_slip) chk(!locked, "R5 no slip while locked", int'(locked), 0);
    if (sgn_slip) begin
      if (slips_s > 0) chk(tk_s >= SETTLE + 1, "R6 sign slip spacing", tk_s, SETTLE + 1);
      slips_s++; tk_s = 0; since = 0; any_slip = 1;
    end
    if (mag_slip) begin
      if (slips_m > 0) chk(tk_m >= SETTLE + 1, "R6 magnitude slip spacing", tk_m, SETTLE + 1);
      slips_m++; tk_m = 0; since = 0; any_slip = 1;
    end
    if (locked && !prev_lock && any_slip)
      chk(since == SETTLE + LOCK_N, "R7 ticks from last slip to lock", since, SETTLE + LOCK_N);
    prev_lock = locked;
  endtask

  task automatic step();
    @(negedge clk);
    observe();
    sgn_bit  = 1'($urandom);
    mag_bit  = 1'($urandom);
    ref_tick = (n == nt);
    if (ref_tick) begin
      nt  = nt + 16 + adj;
      adj = 0;
    end
    sh_h[n & 31] = sgn_bit;
    mh_h[n & 31] = mag_bit;
    rf_h[n & 31] = ref_tick;
    n++;
  endtask

  task automatic wait_tick();
    do step(); while (!ref_tick);
  endtask

  task automatic clear_track();
    slips_s = 0; slips_m = 0; tk_s = 1000; tk_m = 1000; since = 0;
    any_slip = 0; vld_cnt = 0;
  endtask

  task automatic wait_lock(input string tag);
    int k = 0;
    while (!locked && k < 7000) begin step(); k++; end
    chk(locked, {tag, " lock acquired"}, int'(locked), 1);
  endtask

  task automatic do_reset(input logic [3:0] s, input logic [3:0] m);
    track = 0;
    rst_n = 1'b0; sgn_start = s; mag_start = m;
    nt = n + 5 + int'($urandom % 16);
    repeat (4) step();
    chk(!locked && !word_vld && !sgn_slip && !mag_slip, "R5 reset state quiet",
        int'({locked, word_vld, sgn_slip, mag_slip}), 0);
    clear_track();
    prev_lock = 0;
    track = 1;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic scenario(input logic [3:0] s, input logic [3:0] m, input int dir);
    int ps, pm, want;
    do_reset(s, m);
    wait_lock("R4");
    chk(slips_s <= 15 && slips_m <= 15, "R4 slip count bound", slips_s * 256 + slips_m, 15);
    if (s == m) chk(slips_s == slips_m, "R4 equal starts equal slips", slips_s, slips_m);
    vld_cnt = 0;
    repeat (8 * 16) step();
    chk(vld_cnt == 8, "R10 one word per 16 cycles", vld_cnt, 8);
    // three mismatched ticks, then back in phase
    ps = slips_s; pm = slips_m;
    adj = 1; wait_tick(); wait_tick(); wait_tick();
    adj = -1; wait_tick();
    step();
    chk(locked, "R8 three misses keep lock", int'(locked), 1);
    repeat (40) step();
    chk(locked && slips_s == ps && slips_m == pm, "R8 no slip after short glitch",
        int'(locked), 1);
    // permanent shift
    adj = dir; wait_tick();
    wait_tick(); wait_tick(); wait_tick();
    step();
    chk(locked, "R8 lock held through third miss", int'(locked), 1);
    wait_tick(); step();
    chk(!locked, "R8 fourth miss drops lock", int'(locked), 0);
    clear_track();
    wait_lock("R9");
    want = (dir > 0) ? 1 : 15;
    chk(slips_s == want, "R9 sign relock slips", slips_s, want);
    chk(slips_m == want, "R9 magnitude relock slips", slips_m, want);
    vld_cnt = 0;
    repeat (6 * 16) step();
    chk(vld_cnt == 6, "R10 words resume after relock", vld_cnt, 6);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; sgn_start = '0; mag_start = '0;
    sgn_bit = 0; mag_bit = 0; ref_tick = 0; track = 0;
    clear_track();
    scenario(4'd0, 4'd0, 1);
    scenario(4'd15, 4'd3, -1);
    scenario(4'd7, 4'd7, 1);
    scenario(4'd5, 4'd12, -1);
    for (int r = 0; r < 2; r++)
      scenario(4'($urandom), 4'($urandom), (r == 0) ? 1 : -1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule